// File: doc/BRIEF.md
# Two-Bit Register Processor Core

This block is a very small processor. It has two 2-bit general registers, a 2-bit arithmetic unit and a 16-word store of 8-bit instructions. A 4-bit program counter moves through the store one word per clock, with no gaps. Each word is decoded without a register stage into three controls: the source of the second ALU operand, the source of the result, and the register write enable. The chosen result is written into the destination register on the same rising edge that advances the counter. Every instruction therefore takes exactly one cycle. There are no branches and no data memory. When the program counter reaches the last word it wraps to the first and runs the program again.

The instruction store comes up holding the program given by a parameter, and reset restores that program. A load port can overwrite single words. While the load port is active, the core is frozen. The counter and both registers are exposed so that a program's progress can be watched cycle by cycle.

Instruction word: bit 7 selects the class. For ALU words, bits 6:5 give the operation and bit 4 gives operand A. For other words, bits 6:4 give the sub-operation. In both classes, bits 3:1 name the second operand or move source, and bit 0 names the destination.

Top module: `t2_core`

## Requirements
- R1: While `rst` is high at a rising edge, the counter and both registers become 0 and all 16 instruction words are reloaded from parameter `PROG` (word k is `PROG[8k+7:8k]`).
- R2: With `rst` and `ld_en` low, the counter increments by one on every rising edge and wraps from 15 to 0.
- R3: With `ld_en` high (and `rst` low), `ld_data` is written to word `ld_addr`, and the counter and both registers keep their values.
- R4: A word with bit 7 = 0 is an ALU instruction. Operand A is R1 if bit 4 is 1, otherwise R0. Bits 6:5 select the operation: 00 = A+B mod 4, 01 = A-B mod 4, 10 = A AND B, 11 = A OR B. The result goes to R1 if bit 0 is 1, otherwise to R0.
- R5: Bits 3:1 name the second operand. Pattern 1xy is the immediate value xy. Pattern 0rx is register Rr, where r is bit 2 and bit 1 has no effect.
- R6: A word with bit 7 = 1 and bits 6:4 = 000 copies the operand named by bits 3:1 (as in R5) into the register named by bit 0.
- R7: A word with bit 7 = 1 and bits 6:4 nonzero changes neither register.
- R8: The word at counter value k takes effect on the edge that moves the counter from k. The register not named by bit 0 keeps its value on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load-port write strobe; freezes the core |
| ld_addr | input | 4 | Word index written by the load port |
| ld_data | input | 8 | Instruction word written by the load port |
| pc_o | output | 4 | Program counter |
| r0_o | output | 2 | Register R0 |
| r1_o | output | 2 | Register R1 |

## Verification
The checker assumes that `rst` and `ld_en` are known at every edge and that `ld_en` is used only to place words in the store. Under that assumption, every edge is one of three cases: a reset, a frozen load cycle, or one executed instruction. The bench drives both inputs only a nanosecond after a rising edge, so they are always stable at the next sampling edge. It loads programs only through the port. It covers every opcode class, including the encodings in which bit 1 has no effect and the no-op encodings, and it runs past the wrap point.

// File: rtl/t2_pkg.sv
package t2_pkg;

    parameter int DW    = 2;
    parameter int AW    = 4;
    parameter int IW    = 8;
    localparam int DEPTH = 1 << AW;

    typedef logic [DW-1:0] word_t;
    typedef logic [AW-1:0] addr_t;
    typedef logic [IW-1:0] instr_t;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_OR  = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        BS_R0  = 2'b00,
        BS_R1  = 2'b01,
        BS_IMM = 2'b10,
        BS_BAD = 2'b11
    } bsel_e;

    typedef enum logic [1:0] {
        RS_R0  = 2'b00,
        RS_R1  = 2'b01,
        RS_IMM = 2'b10,
        RS_ALU = 2'b11
    } rsel_e;

    typedef struct packed {
        alu_op_e op;
        logic    a_sel;
        bsel_e   bsel;
        rsel_e   rsel;
        word_t   imm;
        logic    dst;
        logic    wen;
    } ctrl_t;

    // Split one instruction word into datapath controls.
    function automatic ctrl_t decode(instr_t w);
        ctrl_t c;
        c.op    = alu_op_e'(w[6:5]);
        c.a_sel = w[4];
        c.bsel  = bsel_e'({w[3], ~w[3] & w[2]});
        c.rsel  = rsel_e'({~w[7] | w[3], ~w[7] | (~w[3] & w[2])});
        c.imm   = w[2:1];
        c.dst   = w[0];
        c.wen   = ~w[7] | (w[6:4] == 3'b000);
        return c;
    endfunction

    function automatic word_t alu(alu_op_e op, word_t a, word_t b);
        word_t y;
        unique case (op)
            OP_ADD: y = a + b;
            OP_SUB: y = a - b;
            OP_AND: y = a & b;
            OP_OR:  y = a | b;
            default: y = '0;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/t2_fetch.sv
module t2_fetch
    import t2_pkg::*;
#(
    parameter logic [DEPTH*IW-1:0] PROG = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ld_en,
    input  addr_t  ld_addr,
    input  instr_t ld_data,
    output addr_t  pc,
    output instr_t instr
);

    instr_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) begin
                store[k] <= PROG[k*IW +: IW];
            end
        end else if (ld_en) begin
            store[ld_addr] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (!ld_en) begin
            pc <= pc + addr_t'(1);
        end
    end

    assign instr = store[pc];

endmodule

// File: rtl/t2_decode.sv
module t2_decode
    import t2_pkg::*;
(
    input  instr_t instr,
    output ctrl_t  ctrl
);

    always_comb begin
        ctrl = decode(instr);
    end

endmodule

// File: rtl/t2_exec.sv
module t2_exec
    import t2_pkg::*;
#(
    parameter int NREG = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  ctrl_t ctrl,
    output word_t r0,
    output word_t r1
);

    word_t regs [NREG];
    word_t opa;
    word_t opb;
    word_t alu_y;
    word_t res;

    always_comb begin
        opa = regs[ctrl.a_sel];
        unique case (ctrl.bsel)
            BS_R0:   opb = regs[0];
            BS_R1:   opb = regs[1];
            BS_IMM:  opb = ctrl.imm;
            default: opb = '0;
        endcase
        alu_y = alu(ctrl.op, opa, opb);
        unique case (ctrl.rsel)
            RS_R0:   res = regs[0];
            RS_R1:   res = regs[1];
            RS_IMM:  res = ctrl.imm;
            RS_ALU:  res = alu_y;
            default: res = '0;
        endcase
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (!hold && ctrl.wen && (int'(ctrl.dst) == g)) begin
                regs[g] <= res;
            end
        end
    end

    assign r0 = regs[0];
    assign r1 = regs[1];

endmodule

// File: rtl/t2_core.sv
module t2_core
    import t2_pkg::*;
#(
    parameter logic [DEPTH*IW-1:0] PROG = {
        8'h84, 8'h44, 8'h64, 8'hF1, 8'h0D, 8'h25, 8'h82, 8'h9E,
        8'h87, 8'h5C, 8'h71, 8'h8C, 8'h31, 8'h04, 8'h8B, 8'h8E
    }
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ld_en,
    input  logic [3:0] ld_addr,
    input  logic [7:0] ld_data,
    output logic [3:0] pc_o,
    output logic [1:0] r0_o,
    output logic [1:0] r1_o
);

    instr_t instr;
    ctrl_t  ctrl;

    t2_fetch #(.PROG(PROG)) u_fetch (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .pc      (pc_o),
        .instr   (instr)
    );

    t2_decode u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    t2_exec u_exec (
        .clk  (clk),
        .rst  (rst),
        .hold (ld_en),
        .ctrl (ctrl),
        .r0   (r0_o),
        .r1   (r1_o)
    );

endmodule

// File: rtl/t2_core_chk.sv
module t2_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       ld_en,
    input logic [3:0] pc,
    input logic [1:0] r0,
    input logic [1:0] r1,
    input logic [7:0] instr
);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pc == 4'd0) && (r0 == 2'd0) && (r1 == 2'd0));

    // R2
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        !ld_en |=> pc == $past(pc) + 4'd1);

    // R3
    a_r3_load_freezes: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> $stable(pc) && $stable(r0) && $stable(r1));

    // R7
    a_r7_nop_no_write: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && instr[7] && (instr[6:4] != 3'b000)) |=> $stable(r0) && $stable(r1));

    // R8
    a_r8_r1_kept: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !instr[0]) |=> $stable(r1));

    // R8
    a_r8_r0_kept: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && instr[0]) |=> $stable(r0));

endmodule

bind t2_core t2_core_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .ld_en (ld_en),
    .pc    (pc_o),
    .r0    (r0_o),
    .r1    (r1_o),
    .instr (instr)
);

// File: tb/tb_t2_core.sv
`timescale 1ns/1ps
module tb_t2_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_en = 1'b0;
    logic [3:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [3:0] pc_o;
    logic [1:0] r0_o;
    logic [1:0] r1_o;

    localparam logic [127:0] DEF_PROG = {
        8'h84, 8'h44, 8'h64, 8'hF1, 8'h0D, 8'h25, 8'h82, 8'h9E,
        8'h87, 8'h5C, 8'h71, 8'h8C, 8'h31, 8'h04, 8'h8B, 8'h8E
    };

    t2_core dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .pc_o(pc_o), .r0_o(r0_o), .r1_o(r1_o)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [3:0] pc;
        logic [1:0] r0;
        logic [1:0] r1;
    } exp_t;

    exp_t  q [$];
    string tq [$];
    int    checks = 0;
    int    fails = 0;
    bit    done = 0;

    // reference model state
    logic [7:0] img [16];
    logic [3:0] m_pc;
    logic [1:0] m_r [2];

    function automatic logic [1:0] src2(logic [7:0] w, logic [1:0] a0, logic [1:0] a1);
        if (w[3]) return w[2:1];
        return w[2] ? a1 : a0;
    endfunction

    task automatic model_exec();
        logic [7:0] w;
        logic [1:0] a, b, y;
        logic       wr;
        w  = img[m_pc];
        b  = src2(w, m_r[0], m_r[1]);
        wr = 1'b0;
        y  = 2'd0;
        if (!w[7]) begin
            a  = w[4] ? m_r[1] : m_r[0];
            wr = 1'b1;
            case (w[6:5])
                2'b00: y = a + b;
                2'b01: y = a - b;
                2'b10: y = a & b;
                default: y = a | b;
            endcase
        end else if (w[6:4] == 3'b000) begin
            wr = 1'b1;
            y  = b;
        end
        if (wr) m_r[w[0]] = y;
        m_pc = m_pc + 4'd1;
    endtask

    // driver: one clock cycle; model updated, expectation pushed after the edge
    task automatic cyc(input logic r, input logic ld, input logic [3:0] la,
                       input logic [7:0] d, input string tag);
        rst = r; ld_en = ld; ld_addr = la; ld_data = d;
        if (r) begin
            m_pc = '0; m_r[0] = '0; m_r[1] = '0;
            for (int k = 0; k < 16; k++) img[k] = DEF_PROG[k*8 +: 8];
        end else if (ld) begin
            img[la] = d;
        end else begin
            model_exec();
        end
        @(posedge clk);
        #1;
        q.push_back('{pc: m_pc, r0: m_r[0], r1: m_r[1]});
        tq.push_back(tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t  e;
            string t;
            e = q.pop_front();
            t = tq.pop_front();
            checks++;
            if (pc_o !== e.pc || r0_o !== e.r0 || r1_o !== e.r1) begin
                fails++;
                $display("FAIL %s: pc/r0/r1 actual %0d/%0d/%0d expected %0d/%0d/%0d",
                         t, pc_o, r0_o, r1_o, e.pc, e.r0, e.r1);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state and reload of the default program
        cyc(1, 0, 0, 0, "R1 reset");
        cyc(1, 0, 0, 0, "R1 reset");
        // R2 R4 R5 R6 R7 R8: default program, past the wrap point
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, "R2/R4/R5/R6/R7/R8 default run");
        // R3: load mid-run, pc at nonzero value, core frozen
        cyc(0, 1, 4'd9, 8'h8F, "R3 load freeze");
        cyc(0, 1, 4'd10, 8'h7B, "R3 load freeze");
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, "R8 after partial load");
        // R3: full program load through the port
        for (int k = 0; k < 16; k++) begin
            logic [7:0] w;
            w = 8'((k * 37 + 11) ^ (k << 5));
            cyc(0, 1, 4'(k), w, "R3 load");
        end
        for (int i = 0; i < 34; i++) cyc(0, 0, 0, 0, "R4/R5/R6/R7 loaded run");
        // R1: reset restores the parameter program
        cyc(1, 0, 0, 0, "R1 mid reset");
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, "R1 reloaded program");
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule